// File: doc/BRIEF.md
# Interval Timer / PWM Generator

This block is an 8-bit counter behind a small byte-wide register bus. A mode bit in its control register decides how the counter works. In interval-timer mode the counter climbs from zero to the value held in a compare register, wraps to zero and raises an interrupt request. In PWM mode the counter runs freely through all 256 states and drives a pulse whose high time equals the compare value. The counter advances on ticks taken from one of four sources: every clock cycle, every 16th cycle, every 64th cycle, or each rising edge of a pulse input that carries another timer's output.

Software configures the block with single-cycle register writes and reads the registers back through a combinational read port. An interrupt request flag is set by hardware and cleared only by writing 0 to it. The interrupt line and the output pin are gated by their own enable bits. Some configuration fields are locked while the counter runs, so that the clock source and the mode cannot change in the middle of a count.

Top module: `tpwm_unit`

## Requirements
- R1: The control register is at bus address 0x12 and the compare register is at 0x13. Control bits are: 7 mode (0 timer, 1 PWM), 6 unused (reads 0), 5:4 clock select, 3 count enable, 2 request flag, 1 pin enable, 0 interrupt enable. A read of any other address returns 0.
- R2: After reset both registers read 0, the pin is low and the interrupt line is low.
- R3: In timer mode the counter starts from 0 and adds 1 on each tick. On a tick where it equals the compare value it returns to 0 and sets the request flag, so the first match comes cmp+1 ticks after counting starts.
- R4: Clock select 00 gives one tick per clock, 01 one tick per 16 clocks, 10 one tick per 64 clocks, and 11 one tick per rising edge of `ext_pulse`. The divider restarts from zero whenever counting is stopped.
- R5: A write to the control register leaves the clock select field unchanged while the count enable bit is 1.
- R6: A write to the control register leaves the mode bit unchanged unless the count enable, interrupt enable and request flag are all 0.
- R7: Writing 0 to bit 2 clears the request flag and writing 1 has no effect. A hardware set in the same cycle as a clearing write wins.
- R8: `pwm_pin` is low whenever the pin enable bit is 0.
- R9: `irq` is high exactly when both the request flag and the interrupt enable are 1.
- R10: In PWM mode the counter runs 0 to 255 and wraps. The pin is high while the count is below the compare value, and each wrap from 255 to 0 sets the request flag.
- R11: In timer mode the pin level toggles on every compare match.
- R12: While count enable is 0 the counter and the toggle state are held at 0 and no event occurs, so restarting begins a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_pulse | input | 1 | External timer pulse, counted on rising edges |
| pwm_pin | output | 1 | Timer toggle or PWM output, gated by pin enable |
| irq | output | 1 | Interrupt request to the controller |

## Verification
The assertions assume that `ext_pulse` is already synchronous to `clk` and that a write strobe lasts one cycle per intended write. The register bus has no back-pressure: every strobe is accepted in the cycle it appears. The bench changes all inputs on the falling clock edge, keeps each external pulse high for at least one full cycle, and separates pulses by low cycles. It always stops counting before it reprograms the clock source or the mode, and it also tries the locked writes on purpose while counting to confirm that they are dropped.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  typedef enum logic [1:0] {
    SEL_DIV1  = 2'b00,
    SEL_DIV16 = 2'b01,
    SEL_DIV64 = 2'b10,
    SEL_EXT   = 2'b11
  } clk_sel_e;

  localparam int BIT_MODE = 7;
  localparam int BIT_SELH = 5;
  localparam int BIT_SELL = 4;
  localparam int BIT_EN   = 3;
  localparam int BIT_FLAG = 2;
  localparam int BIT_OE   = 1;
  localparam int BIT_IE   = 0;
endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
  import tpwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h12,
  parameter logic [ADDR_W-1:0] CMP_ADDR  = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hw_evt,
  output logic              mode,
  output clk_sel_e          sel,
  output logic              en,
  output logic              flag,
  output logic              oe,
  output logic              ie,
  output logic [DATA_W-1:0] cmp,
  output logic [DATA_W-1:0] rdata
);
  logic wr_ctrl, wr_cmp, mode_unlocked;

  assign wr_ctrl       = wr && (addr == CTRL_ADDR);
  assign wr_cmp        = wr && (addr == CMP_ADDR);
  assign mode_unlocked = !en && !ie && !flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= 1'b0;
      sel  <= SEL_DIV1;
      en   <= 1'b0;
      oe   <= 1'b0;
      ie   <= 1'b0;
    end else if (wr_ctrl) begin
      en <= wdata[BIT_EN];
      oe <= wdata[BIT_OE];
      ie <= wdata[BIT_IE];
      if (!en)           sel  <= clk_sel_e'(wdata[BIT_SELH:BIT_SELL]);
      if (mode_unlocked) mode <= wdata[BIT_MODE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            flag <= 1'b0;
    else if (hw_evt)                       flag <= 1'b1;
    else if (wr_ctrl && !wdata[BIT_FLAG])  flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp <= '0;
    else if (wr_cmp) cmp <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) begin
      rdata[BIT_MODE]          = mode;
      rdata[BIT_SELH:BIT_SELL] = sel;
      rdata[BIT_EN]            = en;
      rdata[BIT_FLAG]          = flag;
      rdata[BIT_OE]            = oe;
      rdata[BIT_IE]            = ie;
    end else if (addr == CMP_ADDR) begin
      rdata = cmp;
    end
  end

  a_r5_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && en) |=> (sel == $past(sel)));

  a_r6_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && (en || ie || flag)) |=> (mode == $past(mode)));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |=> flag);

  a_r7_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !hw_evt) |=> !flag);
endmodule

// File: rtl/tpwm_prescale.sv
module tpwm_prescale
  import tpwm_pkg::*;
#(
  parameter int DIV_A = 16,
  parameter int DIV_B = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  clk_sel_e sel,
  input  logic     ext_pulse,
  output logic     tick
);
  localparam int PRE_W = $clog2(DIV_B);
  localparam int A_W   = $clog2(DIV_A);

  logic [PRE_W-1:0] pre;
  logic             ext_q;
  logic             ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) pre <= '0;
    else               pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_pulse;
  end

  assign ext_rise = ext_pulse && !ext_q;

  always_comb begin
    case (sel)
      SEL_DIV1:  tick = en;
      SEL_DIV16: tick = en && (&pre[A_W-1:0]);
      SEL_DIV64: tick = en && (&pre);
      default:   tick = en && ext_rise;
    endcase
  end

  a_r12_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);

  a_r4_ext_single: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_EXT && tick) |=> !tick);
endmodule

// File: rtl/tpwm_core.sv
module tpwm_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  output logic             evt,
  output logic             wave
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             tog;
  logic             match;

  assign match = mode ? (cnt == CNT_TOP) : (cnt == cmp);
  assign evt   = tick && match;

  always_ff @(posedge clk) begin
    if (!rst_n || !en)            cnt <= '0;
    else if (tick && !mode && match) cnt <= '0;
    else if (tick)                cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en)   tog <= 1'b0;
    else if (evt && !mode) tog <= !tog;
  end

  assign wave = mode ? (cnt < cmp) : tog;

  a_r3_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode && tick && cnt == cmp) |=> (cnt == '0));

  a_r10_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode && tick) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r12_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && !tog));

  a_r11_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode && evt && $past(en)) |=> (tog != $past(tog)));
endmodule

// File: rtl/tpwm_unit.sv
module tpwm_unit
  import tpwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int DIV_A  = 16,
  parameter int DIV_B  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ext_pulse,
  output logic              pwm_pin,
  output logic              irq
);
  logic             mode, en, flag, oe, ie, tick, evt, wave;
  clk_sel_e         sel;
  logic [CNT_W-1:0] cmp;

  tpwm_regs #(.ADDR_W(ADDR_W), .DATA_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .hw_evt(evt), .mode(mode), .sel(sel), .en(en),
    .flag(flag), .oe(oe), .ie(ie), .cmp(cmp), .rdata(bus_rdata)
  );

  tpwm_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .sel(sel),
    .ext_pulse(ext_pulse), .tick(tick)
  );

  tpwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .tick(tick),
    .cmp(cmp), .evt(evt), .wave(wave)
  );

  assign pwm_pin = oe && wave;
  assign irq     = flag && ie;

  a_r8_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !pwm_pin);

  a_r9_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && flag));
endmodule

// File: tb/tpwm_unit_tb.sv
module tpwm_unit_tb;
  localparam logic [7:0] A_CTRL = 8'h12;
  localparam logic [7:0] A_CMP  = 8'h13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = A_CTRL;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ext_pulse = 1'b0;
  logic       pwm_pin, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  tpwm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pulse(ext_pulse),
    .pwm_pin(pwm_pin), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = A_CTRL;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = A_CTRL;
    #1;
  endtask

  task automatic wait_flag(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      #1;
      if (bus_rdata[2]) begin n = i; break; end
    end
  endtask

  task automatic stop_all();
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_CTRL, d); check(d == 8'h00, "R2 ctrl", d, 0);
    rd(A_CMP, d);  check(d == 8'h00, "R2 cmp", d, 0);
    check(!pwm_pin && !irq, "R2 outputs", {pwm_pin, irq}, 0);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(A_CMP, 8'hA5);
    rd(A_CMP, d);  check(d == 8'hA5, "R1 cmp readback", d, 8'hA5);
    wr(A_CTRL, 8'h43);
    rd(A_CTRL, d); check(d == 8'h03, "R1 ctrl bit6 zero", d, 8'h03);
    rd(8'h00, d);  check(d == 8'h00, "R1 other address", d, 0);
    stop_all();
  endtask

  task automatic t_timer(input logic [7:0] c, input logic [7:0] ctl, input int exp, input string req);
    int n;
    wr(A_CMP, c);
    wr(A_CTRL, ctl);
    wait_flag(exp + 200, n);
    check(n == exp, req, n, exp);
    stop_all();
  endtask

  task automatic t_ext();
    logic [7:0] d;
    wr(A_CMP, 8'd1);
    wr(A_CTRL, 8'h30);
    @(negedge clk) ext_pulse = 1'b1;
    @(negedge clk) ext_pulse = 1'b0;
    wr(A_CTRL, 8'h38);
    @(negedge clk) ext_pulse = 1'b1;
    repeat (5) @(negedge clk);
    ext_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rd(A_CTRL, d); check(d[2] == 1'b0, "R4 ext first pulse", d[2], 0);
    ext_pulse = 1'b1;
    @(negedge clk) ext_pulse = 1'b0;
    @(negedge clk);
    rd(A_CTRL, d); check(d[2] == 1'b1, "R4 ext second pulse", d[2], 1);
    stop_all();
  endtask

  task automatic t_sel_lock();
    logic [7:0] d;
    wr(A_CMP, 8'hFF);
    wr(A_CTRL, 8'h08);
    wr(A_CTRL, 8'h38);
    rd(A_CTRL, d); check(d[5:4] == 2'b00, "R5 sel locked", d[5:4], 0);
    stop_all();
  endtask

  task automatic t_mode_lock();
    logic [7:0] d;
    wr(A_CTRL, 8'h01);
    wr(A_CTRL, 8'h81);
    rd(A_CTRL, d); check(d == 8'h01, "R6 mode locked by ie", d, 8'h01);
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h80);
    rd(A_CTRL, d); check(d == 8'h80, "R6 mode accepted", d, 8'h80);
    stop_all();
    rd(A_CTRL, d); check(d == 8'h00, "R6 mode back to timer", d, 0);
  endtask

  task automatic t_flag_irq();
    logic [7:0] d;
    int n;
    wr(A_CTRL, 8'h04);
    rd(A_CTRL, d); check(d[2] == 1'b0, "R7 write one no set", d[2], 0);
    wr(A_CMP, 8'd1);
    wr(A_CTRL, 8'h08);
    wait_flag(20, n);
    check(!irq, "R9 irq masked", irq, 0);
    wr(A_CTRL, 8'h05);
    check(irq, "R9 irq raised", irq, 1);
    wr(A_CTRL, 8'h05);
    rd(A_CTRL, d); check(d[2] == 1'b1, "R7 write one keeps flag", d[2], 1);
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, d); check(d[2] == 1'b0, "R7 write zero clears", d[2], 0);
    check(!irq, "R9 irq dropped", irq, 0);
    stop_all();
  endtask

  task automatic t_toggle();
    wr(A_CMP, 8'd2);
    wr(A_CTRL, 8'h0A);
    repeat (2) @(negedge clk);
    check(!pwm_pin, "R11 before match", pwm_pin, 0);
    @(negedge clk);
    check(pwm_pin, "R11 first match", pwm_pin, 1);
    repeat (3) @(negedge clk);
    check(!pwm_pin, "R11 second match", pwm_pin, 0);
    stop_all();
  endtask

  task automatic t_pwm(input logic [7:0] c, input logic [7:0] ctl, input int exp, input string req);
    int highs = 0;
    logic [7:0] d;
    wr(A_CTRL, 8'h80);
    wr(A_CMP, c);
    wr(A_CTRL, ctl);
    for (int i = 0; i < 256; i++) begin
      if (i > 0) @(negedge clk);
      if (pwm_pin) highs++;
    end
    #1;
    check(bus_rdata[2] == 1'b0, {req, " no early wrap"}, bus_rdata[2], 0);
    check(highs == exp, req, highs, exp);
    @(negedge clk);
    rd(A_CTRL, d); check(d[2] == 1'b1, "R10 wrap flag", d[2], 1);
    stop_all();
  endtask

  task automatic t_restart();
    int n;
    wr(A_CMP, 8'd5);
    wr(A_CTRL, 8'h08);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h08);
    wait_flag(50, n);
    check(n == 6, "R12 restart full period", n, 6);
    stop_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_timer(8'd3, 8'h08, 4,   "R3 timer period div1");
    t_timer(8'd0, 8'h08, 1,   "R3 compare zero");
    t_timer(8'd3, 8'h18, 64,  "R4 div16");
    t_timer(8'd1, 8'h28, 128, "R4 div64");
    t_ext();
    t_sel_lock();
    t_mode_lock();
    t_flag_irq();
    t_toggle();
    t_pwm(8'd64, 8'h8A, 64, "R10 duty 64");
    t_pwm(8'd0,  8'h8A, 0,  "R10 duty 0");
    t_pwm(8'd200, 8'h88, 0, "R8 pin disabled");
    t_restart();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule